// File: doc/BRIEF.md
# Programmable Line/Cycle Interrupt Timer

This block is an interrupt timer for a cartridge bus. It advances once per CPU cycle, which is marked by a single-cycle enable. Software programs it through three write strobes that share one 8-bit data bus: a reload value, a control byte and an acknowledge. An 8-bit up-counter counts towards 0xFF. When it is clocked while at 0xFF, it reloads from the reload value and raises an interrupt request. The request stays high until software clears it.

The counter runs in one of two modes. In cycle mode it advances on every enabled CPU cycle. In line mode a prescaler stands between the CPU cycle and the counter. The prescaler starts at a period of 341 and loses 3 on each CPU cycle, so the counter advances about once per video line of 341 dots at three dots per CPU cycle. The acknowledge strobe can re-arm the timer from a saved flag, which lets an interrupt handler restart a periodic timer with a single write.

Top module: `irqt_top`

## Requirements
- R1: After a synchronous reset: `irq` is 0, the timer is disabled, the reload value and the counter are 0, and the prescaler holds its period (341).
- R2: A cycle with `wr_reload` high stores `wr_data` as the 8-bit reload value. Every later reload of the counter takes this value.
- R3: A cycle with `wr_ctrl` high takes its fields from `wr_data`: bit 0 is the re-arm flag, bit 1 is the enable and bit 2 selects cycle mode (1) or line mode (0). If bit 1 is set, the counter loads the reload value held before that cycle and the prescaler returns to 341.
- R4: A control write clears a pending request. If bit 1 is clear, the write does not reload the counter: it keeps its value.
- R5: In cycle mode, each `cpu_tick` cycle while the timer is enabled adds one to the counter. With reload value 0xFE and control 0b110, `irq` stays low after the first tick and goes high after the second.
- R6: When the counter is clocked at 0xFF, it loads the reload value and sets the request. `irq` is active-high and stays high while the request is pending.
- R7: A cycle with `wr_ack` high clears the request and copies the re-arm flag into the enable.
- R8: In line mode, each enabled tick subtracts 3 from the prescaler. When the result would be 0 or less, the prescaler gains 338 (that is, 341 minus 3) and the counter is clocked once. After a restart, the first counter clock falls on the 114th tick.
- R9: No counting takes place while the timer is disabled or `cpu_tick` is low. Both the counter and the prescaler hold their values.
- R10: When strobes coincide, a control write overrides counting in the same cycle. An overflow in the same cycle as an acknowledge leaves the request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | One CPU cycle elapsed |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_ack | input | 1 | Acknowledge strobe |
| wr_data | input | 8 | Write data shared by all strobes |
| irq | output | 1 | Level interrupt request, active-high |

## Verification
Every result of this block is due one rising edge after the stimulus that causes it. This holds for a write, an acknowledge, or the tick that makes the counter wrap: `irq` comes straight from the request flop. The bench drives inputs at the falling edge and applies them across one rising edge. It then samples `irq` one nanosecond later and compares it with a bench-side model that has just been stepped with the same inputs. A cycle-mode wrap can therefore be pinned to the exact tick. A line-mode wrap is checked on the 114th tick and on the tick before it.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int CTRL_REARM_BIT = 0;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_CYC_BIT   = 2;

  typedef struct packed {
    logic cyc;
    logic en;
    logic rearm;
  } irqt_cfg_t;
endpackage

// File: rtl/irqt_ctrl.sv
module irqt_ctrl
  import irqt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_reload,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] reload_q,
  output irqt_cfg_t     cfg_q,
  output logic          restart
);
  assign restart = wr_ctrl && wr_data[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cfg_q    <= '0;
    end else begin
      if (wr_reload) reload_q <= wr_data;
      if (wr_ctrl) begin
        cfg_q.rearm <= wr_data[CTRL_REARM_BIT];
        cfg_q.en    <= wr_data[CTRL_EN_BIT];
        cfg_q.cyc   <= wr_data[CTRL_CYC_BIT];
      end else if (wr_ack) begin
        cfg_q.en <= cfg_q.rearm;
      end
    end
  end

  AST_ACK_REARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && !wr_ctrl) |=> (cfg_q.en == $past(cfg_q.rearm))); // R7
  AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (cfg_q.cyc == $past(wr_data[CTRL_CYC_BIT]))); // R3
endmodule

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic advance,
  output logic line_pulse
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [PW-1:0] PER_V  = PW'(PERIOD);
  localparam logic [PW-1:0] STEP_V = PW'(STEP);
  localparam logic [PW-1:0] WRAP_V = PW'(PERIOD - STEP);

  logic [PW-1:0] pre_q;
  logic          expire;

  assign expire     = (pre_q <= STEP_V);
  assign line_pulse = advance && expire;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= PER_V;
    end else if (advance) begin
      if (expire) pre_q <= pre_q + WRAP_V;
      else        pre_q <= pre_q - STEP_V;
    end
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (pre_q >= PW'(1)) && (pre_q <= PER_V)); // R8
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre_q == PER_V)); // R3
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!advance && !restart) |=> $stable(pre_q)); // R9
endmodule

// File: rtl/irqt_counter.sv
module irqt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         hold,
  input  logic         bump,
  input  logic         ack,
  input  logic [W-1:0] reload,
  output logic         pending
);
  localparam logic [W-1:0] TOP_V = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = bump && (cnt_q == TOP_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (restart)   cnt_q <= reload;
      else if (wrap) cnt_q <= reload;
      else if (bump) cnt_q <= cnt_q + W'(1);

      if (hold)      pending <= 1'b0;
      else if (wrap) pending <= 1'b1;
      else if (ack)  pending <= 1'b0;
    end
  end

  AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wrap && !hold) |=> pending); // R6
  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == $past(reload))); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!bump && !restart) |=> $stable(cnt_q)); // R9
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ack && !hold && !wrap) |=> !pending); // R7
  AST_CTRL_DROPS: assert property (@(posedge clk) disable iff (rst)
    hold |=> !pending); // R4
endmodule

// File: rtl/irqt_top.sv
module irqt_top
  import irqt_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_tick,
  input  logic          wr_reload,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [DW-1:0] wr_data,
  output logic          irq
);
  irqt_cfg_t     cfg;
  logic [DW-1:0] reload;
  logic          restart;
  logic          count_en;
  logic          line_pulse;
  logic          bump;

  irqt_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_reload(wr_reload), .wr_ctrl(wr_ctrl),
    .wr_ack(wr_ack), .wr_data(wr_data), .reload_q(reload),
    .cfg_q(cfg), .restart(restart)
  );

  assign count_en = cfg.en && cpu_tick && !wr_ctrl;
  assign bump     = count_en && (cfg.cyc || line_pulse);

  irqt_prescaler #(.PERIOD(PERIOD), .STEP(STEP)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .advance(count_en && !cfg.cyc), .line_pulse(line_pulse)
  );

  irqt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .hold(wr_ctrl),
    .bump(bump), .ack(wr_ack), .reload(reload), .pending(irq)
  );

  AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en || !cpu_tick) |-> !bump); // R9
  AST_CTRL_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |-> !bump); // R10
endmodule

// File: tb/sim_irqt_top.sv
`timescale 1ns/1ps
module sim_irqt_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_tick, wr_reload, wr_ctrl, wr_ack;
  logic [7:0] wr_data;
  logic       irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string tag  = "R1";

  logic [7:0] m_reload, m_cnt;
  int         m_pre;
  logic       m_en, m_cyc, m_rearm, m_pend;

  always #5 clk = ~clk;

  irqt_top u0 (
    .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .wr_reload(wr_reload),
    .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wr_data(wr_data), .irq(irq)
  );

  task automatic model_reset();
    m_reload = 0; m_cnt = 0; m_pre = 341;
    m_en = 0; m_cyc = 0; m_rearm = 0; m_pend = 0;
  endtask

  task automatic model_step(input bit t, input bit wl, input bit wc,
                            input bit wa, input logic [7:0] d);
    logic [7:0] old_reload = m_reload;
    bit bump = 0;
    bit wrap;
    if (m_en && t && !wc) begin
      if (m_cyc) bump = 1;
      else if (m_pre <= 3) begin bump = 1; m_pre = m_pre + 338; end
      else m_pre = m_pre - 3;
    end
    wrap = bump && (m_cnt == 8'hFF);
    if (wc) m_pend = 0;
    else if (wrap) m_pend = 1;
    else if (wa) m_pend = 0;
    if (wc && d[1]) begin m_cnt = old_reload; m_pre = 341; end
    else if (wrap) m_cnt = old_reload;
    else if (bump) m_cnt = m_cnt + 8'd1;
    if (wc) begin m_rearm = d[0]; m_en = d[1]; m_cyc = d[2]; end
    else if (wa) m_en = m_rearm;
    if (wl) m_reload = d;
  endtask

  task automatic check(input string req);
    vectors++;
    if (irq !== m_pend) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b at %0t", req, irq, m_pend, $time);
    end
  endtask

  task automatic cyc(input bit t, input bit wl, input bit wc, input bit wa,
                     input logic [7:0] d);
    cpu_tick = t; wr_reload = wl; wr_ctrl = wc; wr_ack = wa; wr_data = d;
    @(posedge clk); #1;
    model_step(t, wl, wc, wa, d);
    check(tag);
    @(negedge clk);
    cpu_tick = 0; wr_reload = 0; wr_ctrl = 0; wr_ack = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1; cpu_tick = 0; wr_reload = 0; wr_ctrl = 0; wr_ack = 0; wr_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    tag = "R1"; #1 check(tag);
    ticks(5);                          // R1: disabled after reset, no request

    tag = "R5"; cyc(0, 1, 0, 0, 8'hFE); cyc(0, 0, 1, 0, 8'b110);
    ticks(1);
    if (irq !== 1'b0) begin errors++; $display("FAIL R5: actual %0b expected 0 after first tick", irq); end
    vectors++;
    ticks(1);
    if (irq !== 1'b1) begin errors++; $display("FAIL R5: actual %0b expected 1 after second tick", irq); end
    vectors++;

    tag = "R6"; ticks(3);              // R6: level held, counter reloaded to FE
    tag = "R7"; cyc(0, 0, 0, 1, 8'h00); ticks(1);
    tag = "R2"; cyc(0, 1, 0, 0, 8'hFC); ticks(8);

    tag = "R4"; cyc(0, 1, 0, 0, 8'hF0); cyc(0, 0, 1, 0, 8'b110); ticks(10);
    cyc(0, 0, 1, 0, 8'b101);           // disable, keep count
    tag = "R9"; ticks(50);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 8'h00);
    tag = "R7"; cyc(0, 0, 0, 1, 8'h00);
    tag = "R4"; ticks(5);              // counter continued from FA
    if (irq !== 1'b0) begin errors++; $display("FAIL R4: actual %0b expected 0 before wrap", irq); end
    vectors++;
    ticks(1);
    if (irq !== 1'b1) begin errors++; $display("FAIL R4: actual %0b expected 1 at wrap", irq); end
    vectors++;

    tag = "R8"; cyc(0, 1, 0, 0, 8'hFF); cyc(0, 0, 1, 0, 8'b010);
    ticks(113);
    if (irq !== 1'b0) begin errors++; $display("FAIL R8: actual %0b expected 0 at tick 113", irq); end
    vectors++;
    ticks(1);
    if (irq !== 1'b1) begin errors++; $display("FAIL R8: actual %0b expected 1 at tick 114", irq); end
    vectors++;
    cyc(0, 0, 0, 1, 8'h00);
    ticks(400);

    tag = "R10"; cyc(0, 1, 0, 0, 8'hFF); cyc(0, 0, 1, 0, 8'b111);
    cyc(1, 0, 0, 1, 8'h00);            // wrap and ack together: stays set
    if (irq !== 1'b1) begin errors++; $display("FAIL R10: actual %0b expected 1", irq); end
    vectors++;
    cyc(1, 0, 1, 0, 8'b110);           // control beats tick
    ticks(1);

    tag = "R3";
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      bit t  = ($urandom_range(0, 99) < 75);
      bit wl = (r < 4);
      bit wc = (r >= 4 && r < 7);
      bit wa = (r >= 7 && r < 11) || (m_pend && r >= 11 && r < 20);
      logic [7:0] d = wl ? 8'(8'hE0 | $urandom_range(0, 31)) : 8'($urandom_range(0, 255));
      if (wc && $urandom_range(0, 3) != 0) d[1] = 1'b1;
      cyc(t, wl, wc, wa, d);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule